// File: doc/BRIEF.md
# Linear CCD Line-Transfer Clock Sequencer

This block produces the digital gate phases for a linear photodiode-array image sensor whose output register is a two-phase CCD shift register. From one fast system clock it drives two horizontal shift phases, a transfer gate, a photo gate, an anti-blooming/reset gate and an output reset gate. It also provides a line-valid strobe and a pixel-valid strobe for the video sampler that follows. Every delay and pulse width is a parameter counted in system-clock cycles. The integrator picks the values so that the sensor's nanosecond minimums are met at the chosen clock rate.

A line request starts the charge transfer, which always runs in the same order. First the horizontal phases freeze, with phase 1 high and phase 2 low. Then the transfer gate rises, the photo gate pulses inside the transfer-gate window, and the transfer gate falls. Readout follows: the two horizontal phases alternate for exactly the configured number of pixel periods, and the block then returns to idle. A request that arrives while a line is in progress is held and served as soon as that line has finished. A separate timer starts the anti-blooming/reset pulse a fixed delay after the photo gate falls.

Top module: `line_clock_sequencer`

## Requirements
- R1: After synchronous reset, and while idle, `hclk_a` is 1 and `hclk_b` is 0. Every other output is 0.
- R2: When a request is accepted in idle, the phases stay frozen (`hclk_a`=1, `hclk_b`=0) for T_FRZ cycles before `xfer_gate` rises. Whenever `xfer_gate` is high the phases are frozen, and `xfer_gate` is never high during readout.
- R3: `photo_gate` rises exactly T_TGPG cycles after `xfer_gate` rises and stays high for exactly T_PG cycles. It is only ever high while `xfer_gate` is high.
- R4: `xfer_gate` falls exactly T_PGTG cycles after `photo_gate` falls, so its total width is T_TGPG+T_PG+T_PGTG cycles.
- R5: Readout starts in the cycle after `xfer_gate` falls and lasts exactly N pixel periods of 2*HALF cycles each, where N is the latched pixel count. Each period has HALF cycles with `hclk_a`=1, `hclk_b`=0, followed by HALF cycles with `hclk_a`=0, `hclk_b`=1. The two phases are complementary in every cycle.
- R6: `out_reset` is high during the first RG_W cycles of every `hclk_a`-high half of a pixel period and low at all other times.
- R7: `line_valid` is high for every readout cycle and for no other cycle. `pix_valid` is high exactly during the `hclk_b`-high halves of readout.
- R8: `abr_gate` rises T_ABD cycles after `photo_gate` falls and stays high for T_AB cycles. A new photo-gate fall restarts this timing.
- R9: A request raised while a line is in progress (transfer or readout) is held. The next freeze begins one cycle after the current line ends. Several requests during one line produce a single extra line.
- R10: A pixel count of 0 runs the full transfer sequence but no readout: `line_valid` stays low and the block returns to idle after `xfer_gate` falls.
- R11: The pixel count is sampled in the cycle the request is accepted. Changes to `pix_count` after that have no effect on the current line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_req | input | 1 | Start-of-line request |
| pix_count | input | PIX_W | Pixel periods per line (transition, dark and active) |
| hclk_a | output | 1 | Horizontal shift phase 1 |
| hclk_b | output | 1 | Horizontal shift phase 2 |
| xfer_gate | output | 1 | Transfer gate |
| photo_gate | output | 1 | Photo gate |
| abr_gate | output | 1 | Anti-blooming/photodiode reset gate |
| out_reset | output | 1 | Output-node reset gate |
| line_valid | output | 1 | High during line readout |
| pix_valid | output | 1 | High while the current pixel's output is valid |

## Verification
The assertions check the gate-ordering invariants in every cycle. The phases must be complementary and stay frozen while the transfer gate is high. The photo gate may only be high inside the transfer-gate window, and it must already be low when the transfer gate falls. The output reset may only pulse during phase 1 of readout, and a request that arrives mid-line must be held. The exact cycle counts need the bench's reference model: the freeze, lead, width and tail lengths, the number of pixel periods, the anti-blooming delay and width, and where the pulse restarts on back-to-back lines. The same goes for collapsing several requests into one extra line, for the zero-count case, and for sampling the count when a request is accepted.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_FREEZE,
        XS_TG_LEAD,
        XS_PG_ON,
        XS_TG_TAIL,
        XS_READ
    } xfer_state_t;

    typedef enum logic [1:0] {
        AB_OFF,
        AB_WAIT,
        AB_ON
    } ab_state_t;

    typedef struct packed {
        logic tg;
        logic pg;
    } gate_pair_t;

    typedef struct packed {
        logic ph_a;
        logic ph_b;
        logic rg;
        logic busy;
    } hclk_bus_t;

    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcs_xfer_ctrl.sv
module lcs_xfer_ctrl
    import lcs_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int T_FRZ  = 2,
    parameter int T_TGPG = 2,
    parameter int T_PG   = 25,
    parameter int T_PGTG = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_req,
    input  logic [PIX_W-1:0] pix_count,
    input  logic             read_done,
    output gate_pair_t       gates,
    output logic             read_start,
    output logic [PIX_W-1:0] read_count,
    output logic             pg_end
);

    localparam int XMAX = max2(max2(T_FRZ, T_TGPG), max2(T_PG, T_PGTG));
    localparam int CW   = bits_for(XMAX);
    localparam logic [CW-1:0] L_FRZ  = CW'(T_FRZ - 1);
    localparam logic [CW-1:0] L_TGPG = CW'(T_TGPG - 1);
    localparam logic [CW-1:0] L_PG   = CW'(T_PG - 1);
    localparam logic [CW-1:0] L_PGTG = CW'(T_PGTG - 1);

    xfer_state_t      state;
    logic [CW-1:0]    cnt;
    logic             pend;
    logic [PIX_W-1:0] lat_count;
    logic             step_done;

    assign step_done  = (cnt == '0);
    assign read_start = (state == XS_TG_TAIL) && step_done && (lat_count != '0);
    assign read_count = lat_count;
    assign pg_end     = (state == XS_PG_ON) && step_done;

    always_comb begin
        gates.tg = (state == XS_TG_LEAD) || (state == XS_PG_ON) || (state == XS_TG_TAIL);
        gates.pg = (state == XS_PG_ON);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= XS_IDLE;
            cnt       <= '0;
            pend      <= 1'b0;
            lat_count <= '0;
        end else begin
            if (state == XS_IDLE) begin
                pend <= 1'b0;
            end else if (line_req) begin
                pend <= 1'b1;
            end
            case (state)
                XS_IDLE: begin
                    if (line_req || pend) begin
                        state     <= XS_FREEZE;
                        cnt       <= L_FRZ;
                        lat_count <= pix_count;
                    end
                end
                XS_FREEZE: begin
                    if (step_done) begin
                        state <= XS_TG_LEAD;
                        cnt   <= L_TGPG;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_TG_LEAD: begin
                    if (step_done) begin
                        state <= XS_PG_ON;
                        cnt   <= L_PG;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_PG_ON: begin
                    if (step_done) begin
                        state <= XS_TG_TAIL;
                        cnt   <= L_PGTG;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_TG_TAIL: begin
                    if (step_done) begin
                        state <= (lat_count != '0) ? XS_READ : XS_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                XS_READ: begin
                    if (read_done) begin
                        state <= XS_IDLE;
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    AST_PG_AFTER_TG: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.pg) |-> $past(gates.tg)); // R3
    AST_PG_IN_TG: assert property (@(posedge clk) disable iff (rst)
        gates.pg |-> gates.tg); // R3
    AST_TG_FALL_AFTER_PG: assert property (@(posedge clk) disable iff (rst)
        $fell(gates.tg) |-> !$past(gates.pg)); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == XS_READ && line_req && !read_done) |=> pend); // R9

endmodule

// File: rtl/lcs_pixel_gen.sv
module lcs_pixel_gen
    import lcs_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int HALF  = 4,
    parameter int RG_W  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PIX_W-1:0] count,
    output hclk_bus_t        hbus,
    output logic             pix_b_half,
    output logic             done
);

    localparam int HW    = bits_for(HALF - 1);
    localparam int RG_TH = HALF - RG_W;
    localparam logic [HW-1:0] L_HALF = HW'(HALF - 1);

    logic             active;
    logic             second;
    logic [HW-1:0]    hcnt;
    logic [PIX_W-1:0] left;
    logic             half_end;
    logic             rg_win;

    assign half_end = (hcnt == '0);
    assign done     = active && second && half_end && (left == PIX_W'(1));

    generate
        if (RG_W >= HALF) begin : g_rg_full
            assign rg_win = 1'b1;
        end else begin : g_rg_part
            assign rg_win = (32'(hcnt) >= 32'(RG_TH));
        end
    endgenerate

    always_comb begin
        hbus.busy  = active;
        hbus.ph_a  = !active || !second;
        hbus.ph_b  = active && second;
        hbus.rg    = active && !second && rg_win;
        pix_b_half = active && second;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            second <= 1'b0;
            hcnt   <= '0;
            left   <= '0;
        end else if (start) begin
            active <= 1'b1;
            second <= 1'b0;
            hcnt   <= L_HALF;
            left   <= count;
        end else if (active) begin
            if (!half_end) begin
                hcnt <= hcnt - 1'b1;
            end else if (!second) begin
                second <= 1'b1;
                hcnt   <= L_HALF;
            end else if (left == PIX_W'(1)) begin
                active <= 1'b0;
                second <= 1'b0;
            end else begin
                left   <= left - 1'b1;
                second <= 1'b0;
                hcnt   <= L_HALF;
            end
        end
    end

    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        active |-> (left != '0)); // R5
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |-> !active); // R9

endmodule

// File: rtl/lcs_ab_timer.sv
module lcs_ab_timer
    import lcs_pkg::*;
#(
    parameter int T_ABD = 3,
    parameter int T_AB  = 188
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic ab
);

    localparam int CW = bits_for(max2(T_ABD, T_AB));
    localparam logic [CW-1:0] L_AB = CW'(T_AB - 1);

    ab_state_t     st;
    logic [CW-1:0] cnt;

    assign ab = (st == AB_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= AB_OFF;
            cnt <= '0;
        end else if (trig) begin
            if (T_ABD == 0) begin
                st  <= AB_ON;
                cnt <= L_AB;
            end else begin
                st  <= AB_WAIT;
                cnt <= CW'(T_ABD - 1);
            end
        end else begin
            case (st)
                AB_WAIT: begin
                    if (cnt == '0) begin
                        st  <= AB_ON;
                        cnt <= L_AB;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                AB_ON: begin
                    if (cnt == '0) st <= AB_OFF;
                    else           cnt <= cnt - 1'b1;
                end
                default: st <= AB_OFF;
            endcase
        end
    end

    AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == AB_ON && cnt != '0 && !trig) |=> ab); // R8
    AST_AB_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(ab) |-> ($past(st) == AB_WAIT || $past(trig))); // R8

endmodule

// File: rtl/line_clock_sequencer.sv
module line_clock_sequencer
    import lcs_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int HALF   = 4,
    parameter int RG_W   = 1,
    parameter int T_FRZ  = 2,
    parameter int T_TGPG = 2,
    parameter int T_PG   = 25,
    parameter int T_PGTG = 5,
    parameter int T_ABD  = 3,
    parameter int T_AB   = 188
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_req,
    input  logic [PIX_W-1:0] pix_count,
    output logic             hclk_a,
    output logic             hclk_b,
    output logic             xfer_gate,
    output logic             photo_gate,
    output logic             abr_gate,
    output logic             out_reset,
    output logic             line_valid,
    output logic             pix_valid
);

    gate_pair_t       gates;
    hclk_bus_t        hbus;
    logic             read_start;
    logic             read_done;
    logic [PIX_W-1:0] read_count;
    logic             pg_end;
    logic             b_half;

    lcs_xfer_ctrl #(
        .PIX_W (PIX_W),
        .T_FRZ (T_FRZ),
        .T_TGPG(T_TGPG),
        .T_PG  (T_PG),
        .T_PGTG(T_PGTG)
    ) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .line_req  (line_req),
        .pix_count (pix_count),
        .read_done (read_done),
        .gates     (gates),
        .read_start(read_start),
        .read_count(read_count),
        .pg_end    (pg_end)
    );

    lcs_pixel_gen #(
        .PIX_W(PIX_W),
        .HALF (HALF),
        .RG_W (RG_W)
    ) u_pix (
        .clk       (clk),
        .rst       (rst),
        .start     (read_start),
        .count     (read_count),
        .hbus      (hbus),
        .pix_b_half(b_half),
        .done      (read_done)
    );

    lcs_ab_timer #(
        .T_ABD(T_ABD),
        .T_AB (T_AB)
    ) u_ab (
        .clk (clk),
        .rst (rst),
        .trig(pg_end),
        .ab  (abr_gate)
    );

    assign hclk_a     = hbus.ph_a;
    assign hclk_b     = hbus.ph_b;
    assign out_reset  = hbus.rg;
    assign line_valid = hbus.busy;
    assign pix_valid  = b_half;
    assign xfer_gate  = gates.tg;
    assign photo_gate = gates.pg;

    AST_PHASE_COMPL: assert property (@(posedge clk) disable iff (rst)
        hclk_a != hclk_b); // R5
    AST_FROZEN_XFER: assert property (@(posedge clk) disable iff (rst)
        xfer_gate |-> (hclk_a && !hclk_b && !line_valid)); // R2
    AST_RG_IN_PHASE_A: assert property (@(posedge clk) disable iff (rst)
        out_reset |-> (hclk_a && line_valid)); // R6
    AST_PV_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> (line_valid && hclk_b)); // R7

endmodule

// File: tb/line_clock_sequencer_test.sv
`timescale 1ns/1ps
module line_clock_sequencer_test;

    localparam int PIX_W  = 12;
    localparam int HALF   = 4;
    localparam int RG_W   = 1;
    localparam int T_FRZ  = 2;
    localparam int T_TGPG = 2;
    localparam int T_PG   = 25;
    localparam int T_PGTG = 5;
    localparam int T_ABD  = 3;
    localparam int T_AB   = 188;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_req = 1'b0;
    logic [PIX_W-1:0] pix_count = '0;
    logic hclk_a, hclk_b, xfer_gate, photo_gate, abr_gate, out_reset, line_valid, pix_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 0;

    // reference model state
    int m_t = -1;
    int m_cnt = 0;
    bit m_pend = 0;
    int m_pgfall = -1000000;

    // observed counters
    int lines_seen = 0;
    int pix_seen = 0;
    int tg_seen = 0;
    bit prev_lv = 0, prev_pv = 0, prev_tg = 0;

    always #2 clk = ~clk;

    line_clock_sequencer #(
        .PIX_W(PIX_W), .HALF(HALF), .RG_W(RG_W), .T_FRZ(T_FRZ), .T_TGPG(T_TGPG),
        .T_PG(T_PG), .T_PGTG(T_PGTG), .T_ABD(T_ABD), .T_AB(T_AB)
    ) uut (
        .clk(clk), .rst(rst), .line_req(line_req), .pix_count(pix_count),
        .hclk_a(hclk_a), .hclk_b(hclk_b), .xfer_gate(xfer_gate), .photo_gate(photo_gate),
        .abr_gate(abr_gate), .out_reset(out_reset), .line_valid(line_valid), .pix_valid(pix_valid)
    );

    function automatic int line_end(input int n);
        return T_FRZ + T_TGPG + T_PG + T_PGTG + n * 2 * HALF;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_t = -1;
            m_pend = 0;
            m_pgfall = -1000000;
        end else begin
            if (m_t < 0) begin
                if (line_req || m_pend) begin
                    m_t = 0;
                    m_cnt = int'(pix_count);
                    m_pend = 0;
                end
            end else begin
                if (line_req) m_pend = 1;
                m_t++;
                if (m_t == line_end(m_cnt)) m_t = -1;
                if (m_t == T_FRZ + T_TGPG + T_PG) m_pgfall = cyc;
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            int e_a, e_b, e_tg, e_pg, e_ab, e_rg, e_lv, e_pv, d, u, w, age;
            e_a = 1; e_b = 0; e_tg = 0; e_pg = 0; e_rg = 0; e_lv = 0; e_pv = 0;
            d = T_FRZ + T_TGPG + T_PG + T_PGTG;
            if (m_t >= 0) begin
                e_tg = (m_t >= T_FRZ && m_t < d) ? 1 : 0;
                e_pg = (m_t >= T_FRZ + T_TGPG && m_t < T_FRZ + T_TGPG + T_PG) ? 1 : 0;
                if (m_t >= d) begin
                    u = m_t - d;
                    w = u % (2 * HALF);
                    e_lv = 1;
                    e_a = (w < HALF) ? 1 : 0;
                    e_b = 1 - e_a;
                    e_pv = e_b;
                    e_rg = (w < RG_W && w < HALF) ? 1 : 0;
                end
            end
            age = cyc - m_pgfall;
            e_ab = (age >= T_ABD && age < T_ABD + T_AB) ? 1 : 0;
            chk("R5", "hclk_a", int'(hclk_a), e_a);
            chk("R5", "hclk_b", int'(hclk_b), e_b);
            chk("R2,R4", "xfer_gate", int'(xfer_gate), e_tg);
            chk("R3", "photo_gate", int'(photo_gate), e_pg);
            chk("R8", "abr_gate", int'(abr_gate), e_ab);
            chk("R6", "out_reset", int'(out_reset), e_rg);
            chk("R7", "line_valid", int'(line_valid), e_lv);
            chk("R7", "pix_valid", int'(pix_valid), e_pv);
            if (line_valid && !prev_lv) lines_seen++;
            if (pix_valid && !prev_pv) pix_seen++;
            if (xfer_gate && !prev_tg) tg_seen++;
        end
        prev_lv = line_valid;
        prev_pv = pix_valid;
        prev_tg = xfer_gate;
    end

    task automatic pulse_req();
        @(negedge clk);
        line_req = 1'b1;
        @(negedge clk);
        line_req = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_t >= 0 || m_pend) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_counts();
        lines_seen = 0;
        pix_seen = 0;
        tg_seen = 0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1", "idle vector", int'({hclk_a, hclk_b, xfer_gate, photo_gate, abr_gate,
            out_reset, line_valid, pix_valid}), 8'b1000_0000);

        // R5: single line of three pixels
        pix_count = 12'd3;
        clear_counts();
        pulse_req();
        wait_idle();
        chk("R5", "pixel periods", pix_seen, 3);
        chk("R7", "lines", lines_seen, 1);

        // R5 boundary: one pixel
        pix_count = 12'd1;
        clear_counts();
        pulse_req();
        wait_idle();
        chk("R5", "pixel periods (one)", pix_seen, 1);

        // R9: requests during readout collapse into one extra line
        pix_count = 12'd2;
        clear_counts();
        pulse_req();
        while (!line_valid) @(negedge clk);
        pulse_req();
        pulse_req();
        wait_idle();
        chk("R9", "lines after busy requests", lines_seen, 2);
        chk("R9", "transfers after busy requests", tg_seen, 2);

        // R9: request during transfer phase is also held
        clear_counts();
        pulse_req();
        while (!photo_gate) @(negedge clk);
        pulse_req();
        wait_idle();
        chk("R9", "lines after mid-transfer request", lines_seen, 2);

        // R10: zero count, transfer only
        pix_count = 12'd0;
        clear_counts();
        pulse_req();
        wait_idle();
        chk("R10", "lines with zero count", lines_seen, 0);
        chk("R10", "transfers with zero count", tg_seen, 1);

        // R11: count change after acceptance ignored
        pix_count = 12'd4;
        clear_counts();
        pulse_req();
        pix_count = 12'd7;
        wait_idle();
        chk("R11", "pixel periods with late change", pix_seen, 4);

        // R9/R8: request held high over several lines, AB pulse restarts
        pix_count = 12'd5;
        clear_counts();
        @(negedge clk);
        line_req = 1'b1;
        while (lines_seen < 3) @(negedge clk);
        line_req = 1'b0;
        wait_idle();
        chk("R9", "lines with held request", lines_seen, 4);
        repeat (T_AB + T_ABD + 4) @(negedge clk);
        chk("R8", "abr_gate settled low", int'(abr_gate), 0);
        chk("R1", "idle hclk_a", int'(hclk_a), 1);

        finish_run();
    end

endmodule